// File: doc/BRIEF.md
# Timer Interrupt Router with DMA Steering

This block gathers the interrupt conditions of a five-channel timer. Every channel has three sources: compare/capture A, compare/capture B and counter overflow. Each source owns a request flag, set by a one-cycle event from the timer and held until it is cleared. A source asks for service only while its flag and its enable are both 1.

Among the sources that ask for CPU service, the block picks one winner and presents its 4-bit index with a valid strobe. The fixed order runs from channel 0 down to channel 4, and inside a channel from A to B to overflow. A per-channel priority bit lifts a channel above every channel whose bit is clear.

Source A of channels 0 to 3 can be steered to a DMA request line. A steered source never shows up as a CPU interrupt, and the DMA acknowledge clears its flag. Software clears a flag by reading it as 1 and then writing 0 to it.

Top module: `tmr_irq_router`

## Requirements
- R1: Source index i = 3*channel + offset, where the offset is A=0, B=1 and overflow=2. An `evt_set[i]` pulse sets flag i, and `flags_o[i]` shows that flag.
- R2: A source asks for service only while `flags_o[i]` and `ien[i]` are both 1. A set flag with its enable at 0 gives no `irq_valid`.
- R3: `irq_valid` is 1 exactly when at least one enabled, set, unsteered source exists. `irq_vec` is then the index of the winning source.
- R4: With all `ch_pri` bits equal, the lower channel wins. Inside a channel, A beats B and B beats overflow.
- R5: A channel whose `ch_pri` bit is 1 beats every channel whose bit is 0. Channels with equal bits are ordered as in R4.
- R6: When `dma_sel[c]` is 1 (c = 0..3), source 3c drives `dma_req[c]` (flag AND enable) and is never chosen for `irq_vec`.
- R7: B sources, overflow sources and every channel 4 source ignore `dma_sel` and always take the CPU path.
- R8: A `dma_ack[c]` pulse clears flag 3c when that source is steered. When it is not steered, the pulse has no effect.
- R9: A `sw_rd` pulse arms every flag that reads 1. A following `sw_wr` clears each armed flag whose `sw_wdata` bit is 0, and every `sw_wr` disarms all flags. A write-0 with no prior read leaves the flag set.
- R10: A set event in the same cycle as a software clear or a DMA acknowledge leaves the flag set.
- R11: After reset, all flags are 0, `irq_valid` is 0 and `dma_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set | input | 15 | One-cycle set events from the timer, one per source |
| ien | input | 15 | Per-source enable |
| ch_pri | input | 5 | Per-channel high-priority bit |
| dma_sel | input | 4 | Steer source A of channels 0..3 to DMA |
| dma_ack | input | 4 | DMA acknowledge pulses |
| sw_rd | input | 1 | Flag read strobe (arms the bits read as 1) |
| sw_wr | input | 1 | Flag write strobe |
| sw_wdata | input | 15 | Write data; a 0 bit clears an armed flag |
| flags_o | output | 15 | Current request flags |
| irq_valid | output | 1 | A CPU interrupt is pending |
| irq_vec | output | 4 | Index of the winning source |
| dma_req | output | 4 | DMA requests for channels 0..3 |

## Verification
The assertions check on every cycle that the presented vector points at a set, enabled, unsteered source. They also check that no low-priority channel wins while a high-priority channel is pending, that a DMA request implies a set flag, and that a set event always leaves its flag at 1.

Only the bench scenarios show the rest. These cover the exact winner under every priority setting, the read-then-write clearing protocol, a write with no prior read, acknowledges that must be ignored, and the same-cycle set/clear races.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int NCH = 5,
  localparam int NSRC = 3 * NCH,
  localparam int NDMA = NCH - 1,
  localparam int VW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_set,
  input  logic [NSRC-1:0] ien,
  input  logic [NCH-1:0]  ch_pri,
  input  logic [NDMA-1:0] dma_sel,
  input  logic [NDMA-1:0] dma_ack,
  input  logic            sw_rd,
  input  logic            sw_wr,
  input  logic [NSRC-1:0] sw_wdata,
  output logic [NSRC-1:0] flags_o,
  output logic            irq_valid,
  output logic [VW-1:0]   irq_vec,
  output logic [NDMA-1:0] dma_req
);

  logic [NSRC-1:0] flags, armed, steer, ack_clr, cpu_req, pri_mask;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if ((s % 3 == 0) && (s / 3 < NDMA)) begin : g_dma
      assign steer[s]   = dma_sel[s/3];
      assign ack_clr[s] = dma_sel[s/3] & dma_ack[s/3];
    end else begin : g_cpu
      assign steer[s]   = 1'b0;
      assign ack_clr[s] = 1'b0;
    end
    assign pri_mask[s] = ch_pri[s/3];
  end

  for (genvar c = 0; c < NDMA; c++) begin : g_dreq
    assign dma_req[c] = flags[3*c] & ien[3*c] & dma_sel[c];
  end

  assign cpu_req = flags & ien & ~steer;
  assign flags_o = flags;

  wire [NSRC-1:0] sw_clr = (sw_wr ? (armed & ~sw_wdata) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~(sw_clr | ack_clr)) | evt_set;
      armed <= sw_wr ? '0 : (armed | (sw_rd ? flags : '0));
    end
  end

  always_comb begin
    irq_valid = 1'b0;
    irq_vec   = '0;
    for (int p = 1; p >= 0; p--)
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < 3; s++)
          if (!irq_valid && cpu_req[3*c+s] && (ch_pri[c] == p[0])) begin
            irq_valid = 1'b1;
            irq_vec   = VW'(3*c + s);
          end
  end

  AST_VEC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (flags_o[irq_vec] && ien[irq_vec])); // R2

  AST_NO_CPU_STEERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !steer[irq_vec]); // R6

  AST_PRI_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ch_pri[irq_vec/3]) |-> ((cpu_req & pri_mask) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flags_o & $past(evt_set)) == $past(evt_set))); // R10

  for (genvar c = 0; c < NDMA; c++) begin : g_adma
    AST_DMA_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] |-> flags_o[3*c]); // R6
  end

endmodule

// File: tb/sim_tmr_irq_router.sv
module sim_tmr_irq_router;
  logic clk = 0, rst_n = 0;
  logic [14:0] evt_set = '0, ien = '0, sw_wdata = '1;
  logic [4:0] ch_pri = '0;
  logic [3:0] dma_sel = '0, dma_ack = '0;
  logic sw_rd = 0, sw_wr = 0;
  logic [14:0] flags_o;
  logic irq_valid;
  logic [3:0] irq_vec, dma_req;
  int checks = 0, fails = 0;
  logic done = 0;

  always #4 clk = ~clk;

  tmr_irq_router u0 (.clk, .rst_n, .evt_set, .ien, .ch_pri, .dma_sel, .dma_ack,
    .sw_rd, .sw_wr, .sw_wdata, .flags_o, .irq_valid, .irq_vec, .dma_req);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_set(logic [14:0] m);
    evt_set = m; step(); evt_set = '0;
  endtask

  task automatic clear_all();
    sw_rd = 1; step(); sw_rd = 0;
    sw_wr = 1; sw_wdata = '0; step(); sw_wr = 0; sw_wdata = '1;
  endtask

  function automatic logic [4:0] model(logic [14:0] f, logic [14:0] en,
                                       logic [4:0] pri, logic [3:0] ds);
    for (int p = 1; p >= 0; p--)
      for (int c = 0; c < 5; c++)
        for (int s = 0; s < 3; s++) begin
          automatic int i = 3*c + s;
          automatic bit st = (s == 0 && c < 4) ? ds[c] : 1'b0;
          if (f[i] && en[i] && !st && pri[c] == p[0]) return {1'b1, 4'(i)};
        end
    return 5'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] e;
    logic [14:0] m;
    @(negedge clk); @(negedge clk);
    chk("R11 flags", flags_o, 0);
    chk("R11 valid", irq_valid, 0);
    chk("R11 dma", dma_req, 0);
    rst_n = 1; step();
    chk("R11 flags after release", flags_o, 0);

    ien = '1;
    for (int i = 0; i < 15; i++) begin
      pulse_set(15'(1) << i);
      chk("R1 flag", flags_o, 15'(1) << i);
      chk("R3 vec", {irq_valid, irq_vec}, {1'b1, 4'(i)});
      clear_all();
      chk("R9 cleared", flags_o, 0);
    end

    ien = '0; pulse_set(15'h0010);
    chk("R2 disabled no irq", irq_valid, 0);
    chk("R2 flag still set", flags_o, 15'h0010);
    clear_all();

    ien = '1; pulse_set(15'h7FFF);
    m = 15'h1234;
    for (int p = 0; p < 32; p++)
      for (int k = 0; k < 24; k++) begin
        ch_pri = 5'(p);
        ien = (k == 0) ? 15'h7FFF : m;
        m = {m[13:0], m[14] ^ m[13]};
        #1;
        e = model(15'h7FFF, ien, ch_pri, 4'h0);
        chk(p == 0 ? "R4 default order" : "R5 priority", {irq_valid, irq_vec}, e);
      end
    ch_pri = '0; ien = '1;

    sw_wr = 1; sw_wdata = '0; step(); sw_wr = 0; sw_wdata = '1;
    chk("R9 write without read", flags_o, 15'h7FFF);
    sw_rd = 1; step(); sw_rd = 0;
    sw_wr = 1; sw_wdata = 15'h7FFE; step(); sw_wr = 0; sw_wdata = '1;
    chk("R9 clear bit0 only", flags_o, 15'h7FFE);
    sw_wr = 1; sw_wdata = '0; step(); sw_wr = 0; sw_wdata = '1;
    chk("R9 disarmed by write", flags_o, 15'h7FFE);
    clear_all();

    pulse_set(15'h0004);
    sw_rd = 1; step(); sw_rd = 0;
    sw_wr = 1; sw_wdata = '0; evt_set = 15'h0004; step();
    sw_wr = 0; sw_wdata = '1; evt_set = '0;
    chk("R10 set beats sw clear", flags_o, 15'h0004);
    clear_all();

    for (int c = 0; c < 4; c++) begin
      dma_sel = 4'(1) << c;
      pulse_set(15'(1) << (3*c));
      chk("R6 dma req", dma_req, 4'(1) << c);
      chk("R6 no cpu irq", irq_valid, 0);
      dma_ack = 4'(1) << c; evt_set = 15'(1) << (3*c); step();
      dma_ack = '0; evt_set = '0;
      chk("R10 set beats ack", flags_o, 15'(1) << (3*c));
      dma_ack = 4'(1) << c; step(); dma_ack = '0;
      chk("R8 ack clears", flags_o, 0);
      chk("R8 dma idle", dma_req, 0);
    end

    dma_sel = '0;
    pulse_set(15'h0001);
    dma_ack = 4'h1; step(); dma_ack = '0;
    chk("R8 ack ignored when not steered", flags_o, 15'h0001);
    chk("R8 cpu path", {irq_valid, irq_vec}, 5'h10);
    clear_all();

    dma_sel = 4'hF;
    pulse_set(15'h7FFF & ~15'h0249);
    for (int i = 0; i < 15; i++) begin
      ien = 15'(1) << i; #1;
      if (i % 3 != 0 || i == 12)
        chk("R7 not steerable", {irq_valid, irq_vec, dma_req}, {1'b1, 4'(i), 4'h0});
    end
    dma_sel = '0; ien = '1;
    clear_all();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule